// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block is a watchdog counter that raises a time-out pulse when software fails to clear it in time. It counts ticks from one of two sources, fixed by a static configuration input: a slow tick from a free-running RC oscillator, or the instruction clock, which is the system clock divided by four. The counted ticks first pass through a fixed 8-stage binary divider and then through a 7-bit prescaler. A 3-bit select field picks which prescaler stage ends the count. Select value n gives a time-out every 2^(8+n) ticks, so the range runs from 256 to 32768 ticks.

Software writes the select field through a small register port and reads it back. Software must pulse the clear strobe more often than the chosen period. A halt input models the low-power state. In that state the instruction clock stops, so the watchdog freezes when it uses that source. When it uses the RC source, it keeps counting through halt. A static enable option turns the whole watchdog into a no-op.

The time-out output is a plain control pin. There is no data stream, so no valid/ready handshake is involved.

Top module: `wdog_prescaled`

## Requirements
- R1: With the source option at 0 (instruction clock), one tick is counted every 4 system clock cycles. With the option at 1, one tick is counted for every cycle in which `rc_tick_i` is high.
- R2: With select value n (bits 2..0 of the select register), `timeout_o` pulses once every 2^(8+n) counted ticks. For example, n=0 gives 256 ticks and n=7 gives 32768 ticks.
- R3: `timeout_o` is high for exactly one cycle per time-out. Both the divider and the prescaler restart from zero at that point.
- R4: A one-cycle pulse on `clr_i` while enabled resets the divider and the prescaler to zero. The next time-out then comes one full period later.
- R5: With the instruction-clock source, `halt_i` high stops counting. Counting resumes from the held value when `halt_i` falls.
- R6: With the RC source, `halt_i` has no effect, and the time-out period is unchanged.
- R7: With `cfg_enable_i` low, `timeout_o` stays low. Register writes are ignored, so the readback keeps its reset value. `clr_i` has no effect.
- R8: `sel_rdata_o` reads as {5'b10000, select}. After reset the select value is 3'b111. A write stores only `sel_wdata_i[2:0]`, and bits 7..3 always read as 10000.
- R9: A write to the select field does not reset the counters. The new value is used at the next tap comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable_i | input | 1 | Static option: 1 enables the watchdog |
| cfg_src_rc_i | input | 1 | Static option: 1 selects the RC tick, 0 the instruction clock |
| rc_tick_i | input | 1 | RC oscillator tick, one cycle per RC period, already in the `clk` domain |
| halt_i | input | 1 | Low-power halt state |
| clr_i | input | 1 | Clear-watchdog strobe |
| sel_wr_i | input | 1 | Write strobe for the select register |
| sel_wdata_i | input | 8 | Write data; bits 2..0 are the select field |
| sel_rdata_o | output | 8 | Select register readback |
| timeout_o | output | 1 | One-cycle time-out pulse |

## Verification
A wrong divider or prescaler state, or a bad tap choice, changes the interval between two time-out pulses. A fault of this kind appears within two periods at most, that is, within 2^(9+n) ticks. A phase counter that ignores halt, or a clear that misses a stage, shows up within one period. Either one makes a pulse appear during a window that should stay silent, or moves the pulse out of the expected slot after the clear. Register faults show up on the very next readback cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WD_SEL_W      = 3;
  localparam int WD_DIV_STAGES = 8;
  localparam int WD_INSTR_DIV  = 4;
  localparam int WD_REG_W      = 8;

  typedef enum logic {
    WD_SRC_INSTR = 1'b0,
    WD_SRC_RC    = 1'b1
  } wd_src_e;
endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src
  import wdog_pkg::*;
#(
  parameter int INSTR_DIV = WD_INSTR_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic src_rc_i,
  input  logic rc_tick_i,
  input  logic halt_i,
  output logic tick_o
);
  localparam int PH_W = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(INSTR_DIV - 1);

  wd_src_e          src;
  logic [PH_W-1:0]  phase_q;
  logic             instr_tick;

  assign src = wd_src_e'(src_rc_i);

  // instruction clock phase: frozen while halted
  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      phase_q <= '0;
    end else if (!halt_i) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    end
  end

  assign instr_tick = !halt_i && (phase_q == PH_LAST);

  always_comb begin
    unique case (src)
      WD_SRC_RC:    tick_o = en_i && rc_tick_i;
      default:      tick_o = en_i && instr_tick;
    endcase
  end

  // R5: no instruction tick is produced while halted
  p_halt_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_rc_i && halt_i) |-> !tick_o);

  // R1: instruction ticks never come on back-to-back cycles
  p_instr_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_rc_i && tick_o) |=> !tick_o);
endmodule

// File: rtl/wdog_sel_reg.sv
module wdog_sel_reg
  import wdog_pkg::*;
#(
  parameter int               SEL_W     = WD_SEL_W,
  parameter int               REG_W     = WD_REG_W,
  parameter logic [SEL_W-1:0] SEL_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int FLAG_W = REG_W - SEL_W;
  localparam logic [FLAG_W-1:0] FLAG_VAL = FLAG_W'(1) << (FLAG_W - 1);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_RESET;
    end else if (en_i && wr_i) begin
      sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign sel_o   = sel_q;
  assign rdata_o = {FLAG_VAL, sel_q};

  // R7: writes while disabled leave the field alone
  p_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && wr_i) |=> $stable(sel_q));

  // R8: an enabled write lands in the field
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && wr_i) |=> (sel_q == $past(wdata_i[SEL_W-1:0])));
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain
  import wdog_pkg::*;
#(
  parameter int DIV_STAGES = WD_DIV_STAGES,
  parameter int SEL_W      = WD_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             timeout_o
);
  localparam int TAPS     = 1 << SEL_W;
  localparam int PRE_BITS = TAPS - 1;

  logic [DIV_STAGES-1:0] div_q;
  logic [PRE_BITS-1:0]   pre_q;
  logic [TAPS-1:0]       full;
  logic                  match;
  logic                  to_q;

  // full[k]: divider and prescaler stages below tap k are all ones
  assign full[0] = &div_q;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign full[k] = full[k-1] & pre_q[k-1];
  end

  assign match = full[sel_i];

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      div_q <= '0;
      pre_q <= '0;
      to_q  <= 1'b0;
    end else if (clr_i) begin
      div_q <= '0;
      pre_q <= '0;
      to_q  <= 1'b0;
    end else if (tick_i && match) begin
      div_q <= '0;
      pre_q <= '0;
      to_q  <= 1'b1;
    end else begin
      to_q <= 1'b0;
      if (tick_i) begin
        div_q <= div_q + DIV_STAGES'(1);
        if (&div_q) pre_q <= pre_q + PRE_BITS'(1);
      end
    end
  end

  assign timeout_o = to_q;

  // R4: clear zeroes both stages
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clr_i) |=> (div_q == '0 && pre_q == '0 && !to_q));

  // R3: the counters restart after a time-out
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> (div_q == '0 && pre_q == '0));

  // R2: without a tick the counters hold
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i && !clr_i) |=> ($stable(div_q) && $stable(pre_q)));

  // R7: disabled means no time-out
  p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !to_q);
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int                  DIV_STAGES = WD_DIV_STAGES,
  parameter int                  SEL_W      = WD_SEL_W,
  parameter int                  REG_W      = WD_REG_W,
  parameter int                  INSTR_DIV  = WD_INSTR_DIV,
  parameter logic [SEL_W-1:0]    SEL_RESET  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable_i,
  input  logic             cfg_src_rc_i,
  input  logic             rc_tick_i,
  input  logic             halt_i,
  input  logic             clr_i,
  input  logic             sel_wr_i,
  input  logic [REG_W-1:0] sel_wdata_i,
  output logic [REG_W-1:0] sel_rdata_o,
  output logic             timeout_o
);
  logic             tick;
  logic [SEL_W-1:0] sel;

  wdog_tick_src #(.INSTR_DIV(INSTR_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (cfg_enable_i),
    .src_rc_i  (cfg_src_rc_i),
    .rc_tick_i (rc_tick_i),
    .halt_i    (halt_i),
    .tick_o    (tick)
  );

  wdog_sel_reg #(.SEL_W(SEL_W), .REG_W(REG_W), .SEL_RESET(SEL_RESET)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_enable_i),
    .wr_i    (sel_wr_i),
    .wdata_i (sel_wdata_i),
    .sel_o   (sel),
    .rdata_o (sel_rdata_o)
  );

  wdog_chain #(.DIV_STAGES(DIV_STAGES), .SEL_W(SEL_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (cfg_enable_i),
    .tick_i    (tick),
    .clr_i     (clr_i),
    .sel_i     (sel),
    .timeout_o (timeout_o)
  );

  // R3: the time-out is a single-cycle pulse
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R4: a clear is never followed by a pulse on the next cycle
  p_clear_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable_i && clr_i) |=> !timeout_o);
endmodule

// File: tb/wdog_prescaled_tb_top.sv
module wdog_prescaled_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_enable_i, cfg_src_rc_i, rc_tick_i, halt_i, clr_i, sel_wr_i;
  logic [7:0] sel_wdata_i, sel_rdata_o;
  logic       timeout_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int rc_gap = 1;
  int rc_cnt = 0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wdog_prescaled dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable_i(cfg_enable_i),
    .cfg_src_rc_i(cfg_src_rc_i), .rc_tick_i(rc_tick_i), .halt_i(halt_i),
    .clr_i(clr_i), .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i),
    .sel_rdata_o(sel_rdata_o), .timeout_o(timeout_o)
  );

  // vector table: source, halt, select, rc gap, expected period in clocks
  localparam int NV = 6;
  localparam int V_SRC [NV] = '{0, 0, 1, 1, 1, 1};
  localparam int V_HALT[NV] = '{0, 0, 0, 1, 0, 1};
  localparam int V_SEL [NV] = '{0, 1, 0, 3, 7, 2};
  localparam int V_GAP [NV] = '{1, 1, 3, 2, 1, 1};
  localparam int V_PER [NV] = '{1024, 2048, 768, 4096, 32768, 1024};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit en, input bit src);
    @(negedge clk);
    rst_n = 1'b0; cfg_enable_i = en; cfg_src_rc_i = src;
    halt_i = 1'b0; clr_i = 1'b0; sel_wr_i = 1'b0; sel_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_sel(input logic [7:0] d);
    @(negedge clk); sel_wr_i = 1'b1; sel_wdata_i = d;
    @(negedge clk); sel_wr_i = 1'b0;
  endtask

  task automatic pulse_clr(output int c0);
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0; c0 = cyc;
  endtask

  // returns cycle stamp of next pulse, or -1 when none within max cycles
  task automatic wait_pulse(input int max, output int t);
    t = -1;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (timeout_o) begin t = cyc; return; end
    end
  endtask

  // RC tick generator
  initial begin
    rc_tick_i = 1'b0;
    forever begin
      @(negedge clk);
      rc_cnt = (rc_cnt + 1 >= rc_gap) ? 0 : rc_cnt + 1;
      rc_tick_i = (rc_cnt == 0);
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int t0, t1, c0;
    rst_n = 1'b0;
    cfg_enable_i = 1'b1; cfg_src_rc_i = 1'b0; halt_i = 1'b0;
    clr_i = 1'b0; sel_wr_i = 1'b0; sel_wdata_i = '0;

    // table walk: R1 R2 R3 R6
    for (int v = 0; v < NV; v++) begin
      rc_gap = V_GAP[v];
      do_reset(1'b1, V_SRC[v] != 0);
      wr_sel(8'(V_SEL[v]));
      halt_i = (V_HALT[v] != 0);
      pulse_clr(c0);
      wait_pulse(V_PER[v] + 8, t0);
      chk(t0 >= 0, "R2 first pulse", t0, 1);
      @(negedge clk);
      chk(!timeout_o, "R3 pulse width", int'(timeout_o), 0);
      wait_pulse(V_PER[v] + 8, t1);
      chk(t1 - t0 == V_PER[v], V_HALT[v] != 0 ? "R6 period under halt" : "R1/R2 period",
          t1 - t0, V_PER[v]);
      halt_i = 1'b0;
    end

    // R8 reset value and field layout
    rc_gap = 1;
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    chk(sel_rdata_o == 8'h87, "R8 reset readback", sel_rdata_o, 8'h87);
    wr_sel(8'h05);
    chk(sel_rdata_o == 8'h85, "R8 write readback", sel_rdata_o, 8'h85);
    wr_sel(8'hFF);
    chk(sel_rdata_o == 8'h87, "R8 flag bits fixed", sel_rdata_o, 8'h87);

    // R5 halt freezes instruction-clock counting
    wr_sel(8'h00);
    pulse_clr(c0);
    halt_i = 1'b1;
    wait_pulse(3000, t0);
    chk(t0 < 0, "R5 no pulse while halted", t0, -1);
    halt_i = 1'b0; c0 = cyc;
    wait_pulse(1100, t1);
    chk(t1 - c0 >= 1016 && t1 - c0 <= 1030, "R5 resumes after halt", t1 - c0, 1024);

    // R4 clearing keeps the time-out away
    t0 = -1;
    for (int k = 0; k < 4; k++) begin
      int t;
      pulse_clr(c0);
      wait_pulse(900, t);
      if (t >= 0) t0 = t;
    end
    chk(t0 < 0, "R4 periodic clear", t0, -1);
    pulse_clr(c0);
    wait_pulse(1100, t1);
    chk(t1 - c0 >= 1020 && t1 - c0 <= 1030, "R4 full period after clear", t1 - c0, 1024);

    // R9 select change keeps counter
    do_reset(1'b1, 1'b1);
    wr_sel(8'h01);
    pulse_clr(c0);
    repeat (99) @(negedge clk);
    sel_wr_i = 1'b1; sel_wdata_i = 8'h00;
    @(negedge clk); sel_wr_i = 1'b0;
    wait_pulse(400, t1);
    chk(t1 - c0 >= 254 && t1 - c0 <= 258, "R9 no counter reset on write", t1 - c0, 256);

    // R7 disabled watchdog
    do_reset(1'b0, 1'b0);
    wr_sel(8'h02);
    chk(sel_rdata_o == 8'h87, "R7 write ignored", sel_rdata_o, 8'h87);
    pulse_clr(c0);
    wait_pulse(3000, t0);
    chk(t0 < 0, "R7 no time-out when disabled", t0, -1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule